// File: doc/BRIEF.md
# Flash chip-select and write-strobe sequencer

This block controls two flash devices that share an embedded processor's external bus: a large flash holding program code and a smaller flash used for logging data. The address windows of the two devices may overlap. When they do, the logging device wins. The block masks the code-flash enable whenever the logging select is active. It passes the logging select through to its device unchanged.

Every code-flash access runs through a fixed sequence of bus states. The sequence is one address state, then a parameterised number of wait states, then one closing state. Each bus state is two periods of a double-rate clock, and an input phase bit marks its second half. A small state machine shapes the read enable and the write strobe over this sequence. The write strobe is stretched well past the flash's minimum pulse width and is released half a bus state before the chip enable. Ready is returned to the processor only during the closing state.

Top module: `flash_seq`

## Requirements
- R1: While `logSelN` is low, `execCeN`, `execOeN` and `execWeN` are all high, in the same cycle, whatever the sequencer state.
- R2: `logCeN` always equals `logSelN`, combinationally, including during reset.
- R3: A cycle starts only at a rising `clk2` edge with `phase`=1, in idle, with `execSelN`=0, `logSelN`=1 and exactly one of `rdN`/`wrN` low. A request seen at a `phase`=0 edge is not taken. `execCeN` then stays low for 2*(NUM_WAIT+2) clock periods (12 with NUM_WAIT=4), starting in the first period after the accepting edge.
- R4: In a read cycle, `execOeN` goes low at the first wait state and stays low through the closing state, for 2*(NUM_WAIT+1) periods (10). `execWeN` stays high.
- R5: In a write cycle, `execWeN` goes low at the first wait state for 2*NUM_WAIT+1 periods (9 periods, 225 ns at 25 ns). It rises one period before `execCeN` rises, and `execOeN` stays high.
- R6: `readyN` is low for exactly the two periods of the closing state of each cycle and high otherwise.
- R7: Nothing starts when both `rdN` and `wrN` are low, when neither is low, when `execSelN` is high, or when `logSelN` is low.
- R8: Requests held during an active cycle are ignored. After the closing state the block spends at least one full idle bus state (2 periods) before the next cycle. Back-to-back cycles each receive the full sequence.
- R9: `rstN` low, asynchronously, drives `execCeN`, `execOeN`, `execWeN` and `readyN` high and returns the sequencer to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate clock, two periods per bus state |
| rstN | input | 1 | Asynchronous active-low reset |
| phase | input | 1 | 1 during the second half of each bus state |
| execSelN | input | 1 | Decoded code-flash select, active low |
| logSelN | input | 1 | Decoded logging-flash select, active low |
| rdN | input | 1 | Bus read request, active low |
| wrN | input | 1 | Bus write request, active low |
| execCeN | output | 1 | Code-flash chip enable, active low |
| execOeN | output | 1 | Code-flash output enable, active low |
| execWeN | output | 1 | Code-flash write strobe, active low |
| logCeN | output | 1 | Logging-flash chip enable, active low |
| readyN | output | 1 | Ready to the processor, active low |

## Verification
The bench builds the block with its default NUM_WAIT=4, which makes the wait counter three bits wide. With this setting the full twelve-period enable window, the nine-period write strobe and the ten-period read enable can all be counted slot by slot against hand-computed positions. The setting also covers the closing states of two back-to-back cycles and the one-idle-bus-state gap between them. Because the depth is small, each cycle can be interrupted mid-sequence, either by the logging select or by reset.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_T1,
    S_WAIT,
    S_T2
  } busState_e;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;    // cycle accepted: load wait counter, latch direction
    logic dec;     // end of a wait bus state
    logic ceOn;    // code-flash enable window
    logic xferOn;  // data window (wait states and closing state)
    logic weCut;   // second half of closing state: strobe released
    logic rdyOn;   // closing state: ready to the processor
  } seqStrb_t;

endpackage

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int NUM_WAIT = 4
) (
  input  logic     clk2,
  input  logic     rstN,
  input  logic     phase,
  input  logic     execSelN,
  input  logic     logSelN,
  input  logic     rdN,
  input  logic     wrN,
  input  logic     cntLast,
  output seqStrb_t strb
);

  localparam int TICK_W = $clog2(2 * NUM_WAIT + 1) + 1;

  busState_e state, stateNxt;
  logic      startOk;

  assign startOk = (state == S_IDLE) && phase && !execSelN && logSelN && (rdN ^ wrN);

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE: if (startOk) stateNxt = S_T1;
      S_T1:   if (phase) stateNxt = S_WAIT;
      S_WAIT: if (phase && cntLast) stateNxt = S_T2;
      S_T2:   if (phase) stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk2 or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb.load   = startOk;
    strb.dec    = (state == S_WAIT) && phase;
    strb.ceOn   = (state != S_IDLE);
    strb.xferOn = (state == S_WAIT) || (state == S_T2);
    strb.weCut  = (state == S_T2) && phase;
    strb.rdyOn  = (state == S_T2);
  end

  // Checker: periods spent in the wait states, counted independently
  logic [TICK_W-1:0] waitTicks;
  always_ff @(posedge clk2 or negedge rstN) begin
    if (!rstN)                 waitTicks <= '0;
    else if (state == S_WAIT)  waitTicks <= waitTicks + 1'b1;
    else                       waitTicks <= '0;
  end

  // R3: exactly NUM_WAIT wait states, two periods each
  assert_wait_len_R3: assert property (@(posedge clk2) disable iff (!rstN)
    (state == S_T2 && $past(state) == S_WAIT) |-> waitTicks == TICK_W'(2 * NUM_WAIT));

  // R8: closing state always returns to idle, never chains into a new cycle
  assert_back_to_idle_R8: assert property (@(posedge clk2) disable iff (!rstN)
    (state == S_T2 && phase) |=> state == S_IDLE);

  // R3: a cycle leaves idle only through an accepted start
  assert_start_gate_R3: assert property (@(posedge clk2) disable iff (!rstN)
    (state == S_T1 && $past(state) == S_IDLE) |-> $past(phase) && $past(!execSelN));

endmodule

// File: rtl/flash_seq_dp.sv
module flash_seq_dp
  import flash_seq_pkg::*;
#(
  parameter int NUM_WAIT = 4
) (
  input  logic     clk2,
  input  logic     rstN,
  input  logic     wrN,
  input  logic     logSelN,
  input  seqStrb_t strb,
  output logic     cntLast,
  output logic     execCeN,
  output logic     execOeN,
  output logic     execWeN,
  output logic     logCeN,
  output logic     readyN
);

  localparam int CNT_W = $clog2(NUM_WAIT + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             isWr;

  always_ff @(posedge clk2 or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
      isWr    <= 1'b0;
    end else if (strb.load) begin
      waitCnt <= CNT_W'(NUM_WAIT);
      isWr    <= !wrN;
    end else if (strb.dec && waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  assign cntLast = (waitCnt == CNT_W'(1));

  // Logging select has priority: it masks every code-flash control
  assign execCeN = !(strb.ceOn && logSelN);
  assign execOeN = !(strb.xferOn && !isWr && logSelN);
  assign execWeN = !(strb.xferOn && isWr && !strb.weCut && logSelN);
  assign logCeN  = logSelN;
  assign readyN  = !strb.rdyOn;

  // R3: counter never exceeds its load value
  assert_no_overflow_R3: assert property (@(posedge clk2) disable iff (!rstN)
    waitCnt <= CNT_W'(NUM_WAIT));

  // R1: logging select masks the code flash
  assert_log_priority_R1: assert property (@(posedge clk2) disable iff (!rstN)
    !logSelN |-> execCeN && execOeN && execWeN);

  // R5: strobe only inside the enable, and enable outlives the strobe
  assert_we_in_ce_R5: assert property (@(posedge clk2) disable iff (!rstN)
    !execWeN |-> !execCeN);
  assert_we_hold_R5: assert property (@(posedge clk2) disable iff (!rstN)
    ($rose(execWeN) && logSelN && $past(logSelN)) |-> !execCeN);

  // R4: read and write enables never overlap
  assert_oe_we_excl_R4: assert property (@(posedge clk2) disable iff (!rstN)
    execOeN || execWeN);

  // R6: ready ends with the closing state
  assert_ready_end_R6: assert property (@(posedge clk2) disable iff (!rstN)
    (!readyN && strb.weCut) |=> readyN);

  // R9: reset holds the code-flash controls inactive
  always @(posedge clk2) begin
    if (!rstN) begin
      assert_reset_idle_R9: assert (execCeN && execOeN && execWeN && readyN);
    end
  end

endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int NUM_WAIT = 4
) (
  input  logic clk2,
  input  logic rstN,
  input  logic phase,
  input  logic execSelN,
  input  logic logSelN,
  input  logic rdN,
  input  logic wrN,
  output logic execCeN,
  output logic execOeN,
  output logic execWeN,
  output logic logCeN,
  output logic readyN
);

  seqStrb_t strb;
  logic     cntLast;

  flash_seq_ctrl #(.NUM_WAIT(NUM_WAIT)) uCtrl (
    .clk2     (clk2),
    .rstN     (rstN),
    .phase    (phase),
    .execSelN (execSelN),
    .logSelN  (logSelN),
    .rdN      (rdN),
    .wrN      (wrN),
    .cntLast  (cntLast),
    .strb     (strb)
  );

  flash_seq_dp #(.NUM_WAIT(NUM_WAIT)) uDp (
    .clk2    (clk2),
    .rstN    (rstN),
    .wrN     (wrN),
    .logSelN (logSelN),
    .strb    (strb),
    .cntLast (cntLast),
    .execCeN (execCeN),
    .execOeN (execOeN),
    .execWeN (execWeN),
    .logCeN  (logCeN),
    .readyN  (readyN)
  );

endmodule

// File: tb/tb_flash_seq.sv
`timescale 1ns/100ps
module tb_flash_seq;

  logic clk2 = 1'b0, rstN = 1'b0, phase = 1'b0;
  logic execSelN = 1'b1, logSelN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic execCeN, execOeN, execWeN, logCeN, readyN;

  int checks = 0;
  int errors = 0;

  flash_seq dut (
    .clk2(clk2), .rstN(rstN), .phase(phase), .execSelN(execSelN),
    .logSelN(logSelN), .rdN(rdN), .wrN(wrN), .execCeN(execCeN),
    .execOeN(execOeN), .execWeN(execWeN), .logCeN(logCeN), .readyN(readyN)
  );

  always #2 clk2 = ~clk2;                  // 250 MHz
  always @(negedge clk2) phase <= ~phase;

  // rows: {execSelN,logSelN,rdN,wrN}, ce, oe, we, rdy low-period counts
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {4'b0101, 5'd12, 5'd10, 5'd0, 5'd2},   // read
    {4'b0110, 5'd12, 5'd0,  5'd9, 5'd2},   // write
    {4'b0100, 5'd0,  5'd0,  5'd0, 5'd0},   // both requests
    {4'b0111, 5'd0,  5'd0,  5'd0, 5'd0},   // no request
    {4'b1101, 5'd0,  5'd0,  5'd0, 5'd0},   // not selected
    {4'b0001, 5'd0,  5'd0,  5'd0, 5'd0}    // logging select active
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk2);
    #1;
  endtask

  task automatic alignPh1();
    step();
    while (!phase) step();
  endtask

  task automatic releaseAll();
    execSelN = 1'b1; logSelN = 1'b1; rdN = 1'b1; wrN = 1'b1;
  endtask

  task automatic measure(input logic [3:0] inb, output int ceC, output int oeC,
                         output int weC, output int rdyC, output int ceFirst,
                         output int ceLast, output int weLast, output int logBad);
    ceC = 0; oeC = 0; weC = 0; rdyC = 0; ceFirst = -1; ceLast = -1; weLast = -1; logBad = 0;
    alignPh1();
    {execSelN, logSelN, rdN, wrN} = inb;
    #0.1;
    if (logCeN !== logSelN) logBad++;
    for (int s = 1; s <= 16; s++) begin
      step();
      if (logCeN !== logSelN) logBad++;
      if (!execCeN) begin
        ceC++;
        if (ceFirst < 0) ceFirst = s;
        ceLast = s;
      end
      if (!execOeN) oeC++;
      if (!execWeN) begin weC++; weLast = s; end
      if (!readyN) begin
        rdyC++;
        if (phase) begin rdN = 1'b1; wrN = 1'b1; end
      end
    end
    releaseAll();
  endtask

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements) actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ceC, oeC, weC, rdyC, ceFirst, ceLast, weLast, logBad;

    // Reset state, R9 and R2
    step(); step();
    chk(execCeN && execOeN && execWeN && readyN, "R9 reset outputs", 0, 1);
    logSelN = 1'b0; #0.1;
    chk(logCeN === 1'b0, "R2 pass-through in reset", int'(logCeN), 0);
    logSelN = 1'b1; #0.1;
    chk(logCeN === 1'b1, "R2 pass-through in reset", int'(logCeN), 1);
    rstN = 1'b1;
    step(); step();

    // Vector table
    for (int v = 0; v < NV; v++) begin
      measure(VEC[v][23:20], ceC, oeC, weC, rdyC, ceFirst, ceLast, weLast, logBad);
      chk(ceC == int'(VEC[v][19:15]), $sformatf("R3/R7 ce count row %0d", v), ceC, int'(VEC[v][19:15]));
      chk(oeC == int'(VEC[v][14:10]), $sformatf("R4 oe count row %0d", v), oeC, int'(VEC[v][14:10]));
      chk(weC == int'(VEC[v][9:5]),   $sformatf("R5 we count row %0d", v), weC, int'(VEC[v][9:5]));
      chk(rdyC == int'(VEC[v][4:0]),  $sformatf("R6 ready count row %0d", v), rdyC, int'(VEC[v][4:0]));
      chk(logBad == 0, $sformatf("R2 log pass-through row %0d", v), logBad, 0);
      if (VEC[v][19:15] != 0) begin
        chk(ceFirst == 1, $sformatf("R3 ce start row %0d", v), ceFirst, 1);
        chk(ceLast == 12, $sformatf("R3 ce end row %0d", v), ceLast, 12);
      end
      if (v == 1) chk(weLast == 11, "R5 strobe released one period before enable", weLast, 11);
      step(); step();
    end

    // R3: request seen only at a phase=0 edge is not taken
    step();
    while (phase) step();
    execSelN = 1'b0; rdN = 1'b0;
    step();
    releaseAll();
    ceC = 0;
    for (int s = 0; s < 16; s++) begin
      step();
      if (!execCeN) ceC++;
    end
    chk(ceC == 0, "R3 phase-0 request ignored", ceC, 0);

    // R8: held request gives back-to-back cycles with an idle gap
    begin
      bit ceLow [40];
      int rdyEnds = 0;
      alignPh1();
      execSelN = 1'b0; rdN = 1'b0;
      for (int s = 1; s < 40; s++) begin
        step();
        ceLow[s] = !execCeN;
        if (!readyN && phase) begin
          rdyEnds++;
          if (rdyEnds == 2) releaseAll();
        end
      end
      releaseAll();
      ceC = 0;
      for (int s = 1; s < 40; s++) if (ceLow[s]) ceC++;
      chk(ceC == 24, "R8 two full cycles", ceC, 24);
      chk(!ceLow[13] && !ceLow[14], "R8 idle gap", int'(ceLow[13]) + int'(ceLow[14]), 0);
      chk(ceLow[15] && ceLow[26] && !ceLow[27], "R8 second cycle window",
          int'(ceLow[15]) + int'(ceLow[26]) - int'(ceLow[27]), 2);
    end
    step(); step();

    // R1: logging select asserted mid-cycle masks the code flash
    alignPh1();
    execSelN = 1'b0; rdN = 1'b0;
    for (int s = 1; s <= 5; s++) step();
    chk(!execOeN, "R4 read enable in wait state", int'(execOeN), 0);
    logSelN = 1'b0; #0.1;
    chk(execCeN && execOeN && execWeN, "R1 logging priority", int'(execCeN), 1);
    chk(logCeN === 1'b0, "R2 pass-through mid-cycle", int'(logCeN), 0);
    step();
    logSelN = 1'b1; #0.1;
    chk(!execCeN, "R1 enable resumes after logging select", int'(execCeN), 0);
    for (int s = 0; s < 12; s++) begin
      step();
      if (!readyN && phase) begin rdN = 1'b1; execSelN = 1'b1; end
    end
    releaseAll();
    step(); step();

    // R9: asynchronous reset mid-write
    alignPh1();
    execSelN = 1'b0; wrN = 1'b0;
    for (int s = 1; s <= 5; s++) step();
    chk(!execWeN, "R5 strobe low in wait state", int'(execWeN), 0);
    rstN = 1'b0; #0.1;
    chk(execCeN && execOeN && execWeN && readyN, "R9 async reset mid-cycle", int'(execCeN), 1);
    releaseAll();
    step(); step();
    rstN = 1'b1;
    ceC = 0;
    for (int s = 0; s < 6; s++) begin
      step();
      if (!execCeN) ceC++;
    end
    chk(ceC == 0, "R9 idle after reset", ceC, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule